// File: doc/BRIEF.md
# Byte-Lane Write Strobe Generator

This block drives the active-low byte write strobes of an asynchronous external bus. On a write, it looks at the low two address bits and the transfer-size code. From them it works out which byte lanes of the external port receive data, and it pulls those strobes low for as long as the address strobe is asserted. On a read, or while the address strobe is negated, it keeps every strobe high.

The same decoder serves both a four-byte and a two-byte port, chosen by a mode input. On a two-byte port only the two lower strobes carry meaning. A pin-reuse input can then hand the two upper pins over to two high address bits. The strobe pattern depends only on the address, the size code and the mode. Any size that the external device reports back when it ends the cycle plays no part, so the block has no input for it.

The logic is purely combinational. Each strobe therefore rises and falls in step with the address strobe, with no added cycle of latency.

Top module: `byte_we_gen`

## Requirements
- R1: While the read/write input is high (read) or the address strobe is high (negated), every output that acts as a write strobe is high.
- R2: The outputs are combinational. A change of the address strobe reaches the strobes within the same clock period, with no clock edge in between.
- R3: In four-byte mode, with a write and the address strobe low, lane n (n = 0..3) is low exactly when offset <= n < offset + length. The offset is the value of addr_lo. The length comes from siz: 2'b01 = 1 byte, 2'b10 = 2, 2'b11 = 3, 2'b00 = 4.
- R4: In four-byte mode, we_n[0] goes low only when addr_lo is 2'b00.
- R5: In two-byte mode, we_n[0] goes low only on a write with the address strobe low and addr_lo[0] = 0. addr_lo[1] has no effect.
- R6: In two-byte mode, we_n[1] goes low on a write with the address strobe low whenever addr_lo[0] = 1, and also for any siz other than 2'b01 (byte).
- R7: In two-byte mode with pin_reuse low, we_n[2] and we_n[3] stay high.
- R8: In two-byte mode with pin_reuse high, we_n[2] follows addr_hi[1] (upper address bit) and we_n[3] follows addr_hi[0] (next address bit), whatever the values of rw and as_n.
- R9: In four-byte mode, pin_reuse has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rw | input | 1 | Transfer direction: 1 = read, 0 = write |
| as_n | input | 1 | Address strobe, active low |
| addr_lo | input | 2 | Low address bits, giving the byte offset |
| siz | input | 2 | Transfer size code (01 byte, 10 word, 11 three bytes, 00 long) |
| port32 | input | 1 | Port width: 1 = four-byte port, 0 = two-byte port |
| pin_reuse | input | 1 | In two-byte mode, turn the upper strobe pins into address outputs |
| addr_hi | input | 2 | Upper address bits for pin reuse: [1] goes to pin 2, [0] to pin 3 |
| we_n | output | 4 | Byte write strobes, active low; lane 0 is the lowest offset |

## Verification
Every combination of mode, pin reuse, offset, size code, direction, strobe level and upper address bits is applied and compared with a lane-coverage model. This tells lane spans that wrap at the port edge apart from spans that fit inside it, and odd from even two-byte offsets. A hand-worked table fixes the key patterns independently of that model: long, three-byte, word and byte transfers at each boundary offset, and reused pins during a read. A directed test moves only the address strobe within one clock period and shows that the strobes follow it with no register in the path.

// File: rtl/byte_we_pkg.sv
package byte_we_pkg;

    localparam int WIDE_BYTES   = 4;
    localparam int NARROW_BYTES = 2;
    localparam int WIDE_OFS_W   = $clog2(WIDE_BYTES);
    localparam int NARROW_OFS_W = $clog2(NARROW_BYTES);
    localparam int LEN_W        = $clog2(WIDE_BYTES) + 1;
    localparam int REUSE_LO_PIN = 2;
    localparam int REUSE_HI_PIN = 3;

    typedef enum logic [1:0] {
        SZ_LONG   = 2'b00,
        SZ_BYTE   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_TRIPLE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic                  write_on;
        logic [WIDE_OFS_W-1:0] offset;
        logic [LEN_W-1:0]      length;
    } lane_req_t;

    function automatic logic [LEN_W-1:0] size_to_len(input xfer_size_e sz);
        logic [LEN_W-1:0] n;
        case (sz)
            SZ_BYTE:   n = LEN_W'(1);
            SZ_WORD:   n = LEN_W'(2);
            SZ_TRIPLE: n = LEN_W'(3);
            default:   n = LEN_W'(4);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/byte_we_req.sv
module byte_we_req
    import byte_we_pkg::*;
(
    input  logic                  rw,
    input  logic                  as_n,
    input  logic [WIDE_OFS_W-1:0] addr_lo,
    input  logic [1:0]            siz,
    output lane_req_t             req
);
    always_comb begin
        req.write_on = ~rw & ~as_n;
        req.offset   = addr_lo;
        req.length   = size_to_len(xfer_size_e'(siz));
    end
endmodule

// File: rtl/byte_we_span.sv
module byte_we_span
    import byte_we_pkg::*;
#(
    parameter int PORT_BYTES = 4,
    localparam int OFS_W     = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1,
    localparam int SUM_W     = LEN_W + 1
) (
    input  logic                 active,
    input  logic [OFS_W-1:0]     offset,
    input  logic [LEN_W-1:0]     length,
    output logic [PORT_BYTES-1:0] lane_en
);
    logic [SUM_W-1:0] span_end;

    always_comb span_end = SUM_W'(offset) + SUM_W'(length);

    for (genvar n = 0; n < PORT_BYTES; n++) begin : g_lane
        localparam logic [SUM_W-1:0] LANE_IDX = SUM_W'(n);
        always_comb begin
            lane_en[n] = active
                       && (SUM_W'(offset) <= LANE_IDX)
                       && (span_end > LANE_IDX);
        end
    end
endmodule

// File: rtl/byte_we_pinmux.sv
module byte_we_pinmux
    import byte_we_pkg::*;
(
    input  logic                    port32,
    input  logic                    pin_reuse,
    input  logic [WIDE_BYTES-1:0]   wide_en,
    input  logic [NARROW_BYTES-1:0] narrow_en,
    input  logic [1:0]              addr_hi,
    output logic [WIDE_BYTES-1:0]   we_n
);
    always_comb begin
        we_n = '1;
        if (port32) begin
            we_n = ~wide_en;
        end else begin
            we_n[NARROW_BYTES-1:0] = ~narrow_en;
            if (pin_reuse) begin
                we_n[REUSE_LO_PIN] = addr_hi[1];
                we_n[REUSE_HI_PIN] = addr_hi[0];
            end
        end
    end
endmodule

// File: rtl/byte_we_gen.sv
module byte_we_gen
    import byte_we_pkg::*;
(
    input  logic                  rw,
    input  logic                  as_n,
    input  logic [WIDE_OFS_W-1:0] addr_lo,
    input  logic [1:0]            siz,
    input  logic                  port32,
    input  logic                  pin_reuse,
    input  logic [1:0]            addr_hi,
    output logic [WIDE_BYTES-1:0] we_n
);
    lane_req_t                 req;
    logic [WIDE_BYTES-1:0]     wide_en;
    logic [NARROW_BYTES-1:0]   narrow_en;

    byte_we_req u_req (
        .rw      (rw),
        .as_n    (as_n),
        .addr_lo (addr_lo),
        .siz     (siz),
        .req     (req)
    );

    byte_we_span #(.PORT_BYTES(WIDE_BYTES)) u_span_wide (
        .active  (req.write_on),
        .offset  (req.offset),
        .length  (req.length),
        .lane_en (wide_en)
    );

    byte_we_span #(.PORT_BYTES(NARROW_BYTES)) u_span_narrow (
        .active  (req.write_on),
        .offset  (req.offset[NARROW_OFS_W-1:0]),
        .length  (req.length),
        .lane_en (narrow_en)
    );

    byte_we_pinmux u_mux (
        .port32    (port32),
        .pin_reuse (pin_reuse),
        .wide_en   (wide_en),
        .narrow_en (narrow_en),
        .addr_hi   (addr_hi),
        .we_n      (we_n)
    );
endmodule

// File: rtl/byte_we_gen_chk.sv
module byte_we_gen_chk
    import byte_we_pkg::*;
(
    input logic                  rw,
    input logic                  as_n,
    input logic [WIDE_OFS_W-1:0] addr_lo,
    input logic [1:0]            siz,
    input logic                  port32,
    input logic                  pin_reuse,
    input logic [1:0]            addr_hi,
    input logic [WIDE_BYTES-1:0] we_n
);
    logic reused;
    logic idle;

    always_comb begin
        reused = ~port32 & pin_reuse;
        idle   = rw | as_n;

        if (idle && !reused)
            assert_idle_high_R1: assert (we_n == '1)
                else $error("strobe active while idle");

        if (port32 && !idle)
            assert_some_lane_R3: assert ($countones(~we_n) >= 1)
                else $error("no lane on active four-byte write");

        if (port32 && !we_n[0])
            assert_lane0_aligned_R4: assert (addr_lo == '0)
                else $error("lane 0 on unaligned offset");

        if (!port32 && !we_n[0])
            assert_narrow_lane0_even_R5: assert (!addr_lo[0] && !idle)
                else $error("two-byte lane 0 on odd offset");

        if (!port32 && !we_n[1])
            assert_narrow_lane1_R6: assert (!idle && (addr_lo[0] || siz != 2'b01))
                else $error("two-byte lane 1 on even byte");

        if (!port32 && !pin_reuse)
            assert_upper_idle_R7: assert (we_n[3:2] == 2'b11)
                else $error("upper pins active in two-byte mode");

        if (reused)
            assert_addr_pins_R8: assert (we_n[3] == addr_hi[0] && we_n[2] == addr_hi[1])
                else $error("reused pins do not carry address");
    end
endmodule

bind byte_we_gen byte_we_gen_chk u_chk (
    .rw        (rw),
    .as_n      (as_n),
    .addr_lo   (addr_lo),
    .siz       (siz),
    .port32    (port32),
    .pin_reuse (pin_reuse),
    .addr_hi   (addr_hi),
    .we_n      (we_n)
);

// File: tb/byte_we_gen_tb.sv
module byte_we_gen_tb;

    logic       clk = 1'b0;
    logic       rw, as_n, port32, pin_reuse;
    logic [1:0] addr_lo, siz, addr_hi;
    logic [3:0] we_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    byte_we_gen u_dut (
        .rw        (rw),
        .as_n      (as_n),
        .addr_lo   (addr_lo),
        .siz       (siz),
        .port32    (port32),
        .pin_reuse (pin_reuse),
        .addr_hi   (addr_hi),
        .we_n      (we_n)
    );

    // {port32, reuse, rw, as_n, addr_lo[2], siz[2], addr_hi[2], expected we_n[4]}
    localparam int NVEC = 14;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1,1'b0,1'b0,1'b0,2'd0,2'b00,2'b00,4'b0000}, // R3 long at 0
        {1'b1,1'b0,1'b0,1'b0,2'd1,2'b01,2'b00,4'b1101}, // R3 byte at 1
        {1'b1,1'b0,1'b0,1'b0,2'd1,2'b10,2'b00,4'b1001}, // R3 word at 1
        {1'b1,1'b0,1'b0,1'b0,2'd1,2'b11,2'b00,4'b0001}, // R3 three at 1
        {1'b1,1'b0,1'b0,1'b0,2'd3,2'b00,2'b00,4'b0111}, // R4 long at 3
        {1'b1,1'b0,1'b0,1'b0,2'd2,2'b00,2'b00,4'b0011}, // R3 long at 2
        {1'b0,1'b0,1'b0,1'b0,2'd0,2'b01,2'b00,4'b1110}, // R5 byte even
        {1'b0,1'b0,1'b0,1'b0,2'd1,2'b01,2'b00,4'b1101}, // R6 byte odd
        {1'b0,1'b0,1'b0,1'b0,2'd2,2'b10,2'b00,4'b1100}, // R5 word, A1 ignored
        {1'b0,1'b0,1'b0,1'b0,2'd1,2'b00,2'b00,4'b1101}, // R6 long odd
        {1'b0,1'b1,1'b0,1'b0,2'd0,2'b10,2'b10,4'b0100}, // R8 word, pins carry addr
        {1'b0,1'b1,1'b1,1'b0,2'd0,2'b00,2'b01,4'b1011}, // R8 read, pins carry addr
        {1'b1,1'b0,1'b1,1'b0,2'd0,2'b00,2'b00,4'b1111}, // R1 read
        {1'b1,1'b1,1'b0,1'b0,2'd0,2'b00,2'b11,4'b0000}  // R9 reuse ignored
    };

    function automatic logic [3:0] model(input logic p32, input logic reuse,
                                         input logic r, input logic a,
                                         input logic [1:0] ofs, input logic [1:0] sz,
                                         input logic [1:0] hi);
        logic [3:0] w;
        int bytes, o, len;
        w     = 4'hF;
        bytes = p32 ? 4 : 2;
        o     = p32 ? int'(ofs) : int'(ofs[0]);
        len   = (sz == 2'b00) ? 4 : int'(sz);
        for (int n = 0; n < bytes; n++)
            if (!r && !a && o <= n && o + len > n) w[n] = 1'b0;
        if (!p32 && reuse) begin
            w[2] = hi[1];
            w[3] = hi[0];
        end
        return w;
    endfunction

    function automatic string tag_of(input logic p32, input logic reuse,
                                     input logic r, input logic a);
        if (!p32 && reuse) return "R8";
        if (r || a)        return "R1";
        if (p32)           return reuse ? "R9" : "R3";
        return "R5 R6 R7";
    endfunction

    task automatic check(input logic [3:0] exp, input string req, input string what);
        n_cmp++;
        if (we_n !== exp) begin
            n_bad++;
            $display("FAIL %s %s: we_n=%b expected=%b", req, what, we_n, exp);
        end
    endtask

    task automatic apply(input logic p32, input logic reuse, input logic r, input logic a,
                         input logic [1:0] ofs, input logic [1:0] sz, input logic [1:0] hi);
        @(negedge clk);
        port32 = p32; pin_reuse = reuse; rw = r; as_n = a;
        addr_lo = ofs; siz = sz; addr_hi = hi;
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        port32 = 1'b1; pin_reuse = 1'b0; rw = 1'b1; as_n = 1'b1;
        addr_lo = '0; siz = '0; addr_hi = '0;
        #2;
        check(4'hF, "R1", "idle at start");

        // hand-worked table
        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] v;
            v = VEC[i];
            apply(v[13], v[12], v[11], v[10], v[9:8], v[7:6], v[5:4]);
            check(v[3:0], "R3 R4 R5 R6 R8 R9 R1", $sformatf("table vector %0d", i));
        end

        // exhaustive sweep against lane-coverage model
        for (int m = 0; m < 2; m++)
            for (int ru = 0; ru < 2; ru++)
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < 2; s++)
                        for (int o = 0; o < 4; o++)
                            for (int z = 0; z < 4; z++)
                                for (int h = 0; h < 4; h++) begin
                                    apply(m[0], ru[0], d[0], s[0], o[1:0], z[1:0], h[1:0]);
                                    check(model(m[0], ru[0], d[0], s[0], o[1:0], z[1:0], h[1:0]),
                                          tag_of(m[0], ru[0], d[0], s[0]),
                                          $sformatf("sweep m=%0d r=%0d rw=%0d as=%0d o=%0d s=%0d h=%0d",
                                                    m, ru, d, s, o, z, h));
                                end

        // R2: strobe follows as_n within one clock period
        apply(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 2'b00);
        check(4'hF, "R2", "write set up, strobe negated");
        as_n = 1'b0;
        #1;
        check(4'h0, "R2", "assert within same period");
        as_n = 1'b1;
        #1;
        check(4'hF, "R2", "negate within same period");

        // R7: two-byte mode, reuse off, upper pins high on long write
        apply(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 2'b11);
        check(4'b1100, "R7", "upper pins idle");

        // R8: reused pins ignore strobe negation
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'b00, 2'b01);
        check(4'b1011, "R8", "address on pins while strobe negated");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule